// File: doc/BRIEF.md
# Multi-Rate TDM Serial Stream Converter

This block sits between two local serial TDM pins in each direction and a byte-wide, channel-indexed interface. It always presents 64 channels per direction. The pins of one direction can be used in three ways. In the first, two independent 2.048 Mbps streams use both pins. In the second, one 4.096 Mbps stream uses pin 0. In the third, pin 0 carries an 8.192 Mbps stream, and the block owns either its even or its odd slots. The receive side and the transmit side each have their own mode and parity setting.

Timing comes from a single clock running at the 8.192 MHz bit rate. A frame is 1024 clock cycles (125 µs). A 2 Mbps bit cell is 4 cycles long, a 4 Mbps cell is 2 cycles and an 8 Mbps cell is 1 cycle. A one-cycle frame-sync pulse aligns the internal slot counter. After that pulse the counter runs freely, frame after frame.

On the receive side the block delivers one byte and its channel number per lane for every slot it owns. On the transmit side it asks for the byte of a channel one cycle before that slot starts and serialises it MSB first. Whenever a transmit pin has nothing to send, its output enable is low.

Top module: `tdmStreamConverter`

## Requirements
- R1: After reset, and until the first frameSync pulse, txOe, rxValid and txReq stay 0.
- R2: If frameSync is high in cycle t, then cycle t+1 is frame position 0: bit 7 of slot 0. Positions then advance by one per cycle and wrap from 1023 back to 0 without another pulse.
- R3: Mode code 0 (dual 2 Mbps) uses 4-cycle bit cells and 32 slots per pin. Pin 0 slot s is channel s and pin 1 slot s is channel 32+s.
- R4: Mode code 1 (single 4 Mbps) uses 2-cycle bit cells and 64 slots on pin 0, where slot s is channel s. In this mode lane 1 never drives its pin, never asks for a byte, and ignores its receive pin.
- R5: Mode code 2 (half 8 Mbps) uses 1-cycle bit cells and 128 slots on pin 0. Only slots whose bit 0 equals the parity input (0 = even, 1 = odd) are handled, and slot s maps to channel s>>1. In the other slots the pin is disabled on transmit and ignored on receive. Lane 1 is idle.
- R6: Mode code 3 switches its direction off: no output enable, no byte request, no received byte.
- R7: Bits travel MSB first. A transmitted bit is held on the pin for its whole cell, starting in the first cycle of the cell. A received bit is sampled in the last cycle of its cell.
- R8: txReq of a lane goes high for exactly one cycle: the cycle before that lane's slot starts. txChan gives the channel in that same cycle, and txData is captured in that cycle. The output enable rises only right after such a request.
- R9: A received byte appears as a one-cycle rxValid pulse, with rxChan and rxByte, in the cycle after the last cycle of its slot.
- R10: The receive mode and parity are independent of the transmit mode and parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one cycle per 8 Mbps bit |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | One-cycle pulse; the next cycle is frame position 0 |
| rxMode | input | 2 | Receive mode: 0 dual, 1 single, 2 half-8, 3 off |
| rxOddHalf | input | 1 | Receive parity in half-8 mode (1 = odd slots) |
| txMode | input | 2 | Transmit mode, same encoding as rxMode |
| txOddHalf | input | 1 | Transmit parity in half-8 mode |
| rxPin | input | 2 | Serial receive pins |
| rxValid | output | 2 | Per-lane received-byte strobe |
| rxChan0 | output | 6 | Channel of the lane 0 received byte |
| rxByte0 | output | 8 | Lane 0 received byte |
| rxChan1 | output | 6 | Channel of the lane 1 received byte |
| rxByte1 | output | 8 | Lane 1 received byte |
| txReq | output | 2 | Per-lane transmit byte request |
| txChan0 | output | 6 | Channel requested on lane 0 |
| txData0 | input | 8 | Byte for lane 0, captured while txReq[0] is high |
| txChan1 | output | 6 | Channel requested on lane 1 |
| txData1 | input | 8 | Byte for lane 1, captured while txReq[1] is high |
| txPin | output | 2 | Serial transmit pins |
| txOe | output | 2 | Transmit output enable (low = high impedance) |

## Verification
At every slot boundary the last receive sample of one slot and the transmit byte request for the next slot fall in the same cycle. In dual mode the two lanes also finish their slots together. The bench connects the transmit pins back to the receive pins, with a pull-up wherever the enable is low, and runs full frames across a table of mode and parity pairs. A run passes only if every one of the 64 channels comes back exactly once with the byte that was requested for it, or with all ones when the far side is silent. The output-enable cycle count must also match the mode, so a request or a capture lost at a boundary shows up as a missing channel or a wrong byte.

// File: rtl/tdmPkg.sv
package tdmPkg;
  localparam int POS_W     = 10;               // clock cycles per frame = 2**POS_W
  localparam int BYTE_W    = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);
  localparam int CHAN_W    = POS_W - BIT_IDX_W - 1;
  localparam int LANES     = 2;

  typedef enum logic [1:0] {
    MODE_DUAL2   = 2'd0,
    MODE_SINGLE4 = 2'd1,
    MODE_HALF8   = 2'd2,
    MODE_OFF     = 2'd3
  } mode_e;

  typedef struct packed {
    logic [LANES-1:0]  act;
    logic              bitFirst;
    logic              slotFirst;
    logic [CHAN_W-1:0] chan0;
    logic [CHAN_W-1:0] chan1;
  } txStb_t;

  typedef struct packed {
    logic [LANES-1:0]  act;
    logic              bitLast;
    logic              slotLast;
    logic [CHAN_W-1:0] chan0;
    logic [CHAN_W-1:0] chan1;
  } rxStb_t;

  function automatic txStb_t decodeTx(input logic [POS_W-1:0] pos, input mode_e mode,
                                      input logic odd, input logic en);
    txStb_t t;
    t = '0;
    if (en) begin
      case (mode)
        MODE_DUAL2: begin
          t.act       = 2'b11;
          t.bitFirst  = (pos[1:0] == 2'b00);
          t.slotFirst = (pos[BIT_IDX_W+1:0] == '0);
          t.chan0     = {1'b0, pos[POS_W-1:BIT_IDX_W+2]};
          t.chan1     = {1'b1, pos[POS_W-1:BIT_IDX_W+2]};
        end
        MODE_SINGLE4: begin
          t.act       = 2'b01;
          t.bitFirst  = !pos[0];
          t.slotFirst = (pos[BIT_IDX_W:0] == '0);
          t.chan0     = pos[POS_W-1:BIT_IDX_W+1];
        end
        MODE_HALF8: begin
          t.act       = {1'b0, pos[BIT_IDX_W] == odd};
          t.bitFirst  = 1'b1;
          t.slotFirst = (pos[BIT_IDX_W-1:0] == '0);
          t.chan0     = pos[POS_W-1:BIT_IDX_W+1];
        end
        default: ;
      endcase
    end
    return t;
  endfunction

  function automatic rxStb_t decodeRx(input logic [POS_W-1:0] pos, input mode_e mode,
                                      input logic odd, input logic en);
    rxStb_t r;
    r = '0;
    if (en) begin
      case (mode)
        MODE_DUAL2: begin
          r.act      = 2'b11;
          r.bitLast  = &pos[1:0];
          r.slotLast = &pos[BIT_IDX_W+1:0];
          r.chan0    = {1'b0, pos[POS_W-1:BIT_IDX_W+2]};
          r.chan1    = {1'b1, pos[POS_W-1:BIT_IDX_W+2]};
        end
        MODE_SINGLE4: begin
          r.act      = 2'b01;
          r.bitLast  = pos[0];
          r.slotLast = &pos[BIT_IDX_W:0];
          r.chan0    = pos[POS_W-1:BIT_IDX_W+1];
        end
        MODE_HALF8: begin
          r.act      = {1'b0, pos[BIT_IDX_W] == odd};
          r.bitLast  = 1'b1;
          r.slotLast = &pos[BIT_IDX_W-1:0];
          r.chan0    = pos[POS_W-1:BIT_IDX_W+1];
        end
        default: ;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/tdmSlotCtrl.sv
module tdmSlotCtrl
  import tdmPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameSync,
  input  logic [1:0] rxMode,
  input  logic       rxOddHalf,
  input  logic [1:0] txMode,
  input  logic       txOddHalf,
  output rxStb_t     rxStb,
  output txStb_t     txStb
);
  logic [POS_W-1:0] posQ;
  logic [POS_W-1:0] posNext;
  logic             synced;

  // frameSync makes the following cycle position 0; otherwise free-running wrap
  assign posNext = frameSync ? '0 : posQ + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posQ   <= '0;
      synced <= 1'b0;
    end else begin
      posQ <= posNext;
      if (frameSync) synced <= 1'b1;
    end
  end

  // receive works on the current position, transmit looks one cycle ahead
  assign rxStb = decodeRx(posQ, mode_e'(rxMode), rxOddHalf, synced);
  assign txStb = decodeTx(posNext, mode_e'(txMode), txOddHalf, synced | frameSync);

  assert_lane1_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txMode == MODE_SINGLE4) |-> !txStb.act[1]);

  assert_off_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txMode == MODE_OFF && rxMode == MODE_OFF) |-> (txStb.act == '0 && rxStb.act == '0));
endmodule

// File: rtl/tdmLaneDatapath.sv
module tdmLaneDatapath
  import tdmPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxStb_t            rxStb,
  input  txStb_t            txStb,
  input  logic [LANES-1:0]  rxPin,
  input  logic [BYTE_W-1:0] txData [LANES],
  output logic [LANES-1:0]  txReq,
  output logic [LANES-1:0]  txPin,
  output logic [LANES-1:0]  txOe,
  output logic [LANES-1:0]  rxValid,
  output logic [BYTE_W-1:0] rxByte [LANES],
  output logic [CHAN_W-1:0] rxChan [LANES]
);
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [BYTE_W-1:0] txSh;
    logic              oeQ;
    logic [BYTE_W-1:0] rxSh;
    logic [BYTE_W-1:0] byteQ;
    logic [CHAN_W-1:0] chanQ;
    logic              validQ;
    logic [CHAN_W-1:0] rxChanHere;

    if (g == 0) begin : gC0
      assign rxChanHere = rxStb.chan0;
    end else begin : gC1
      assign rxChanHere = rxStb.chan1;
    end

    assign txReq[g] = txStb.slotFirst & txStb.act[g];
    assign txPin[g] = oeQ & txSh[BYTE_W-1];
    assign txOe[g]  = oeQ;

    // transmit: load at slot start, shift at each new cell, release when idle
    always_ff @(posedge clk) begin
      if (!rstN) begin
        txSh <= '0;
        oeQ  <= 1'b0;
      end else if (txReq[g]) begin
        txSh <= txData[g];
        oeQ  <= 1'b1;
      end else if (!txStb.act[g]) begin
        oeQ  <= 1'b0;
      end else if (txStb.bitFirst) begin
        txSh <= txSh << 1;
      end
    end

    // receive: sample in last cycle of each cell, publish after the slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rxSh   <= '0;
        byteQ  <= '0;
        chanQ  <= '0;
        validQ <= 1'b0;
      end else begin
        validQ <= rxStb.act[g] & rxStb.slotLast;
        if (rxStb.act[g] && rxStb.bitLast)
          rxSh <= {rxSh[BYTE_W-2:0], rxPin[g]};
        if (rxStb.act[g] && rxStb.slotLast) begin
          byteQ <= {rxSh[BYTE_W-2:0], rxPin[g]};
          chanQ <= rxChanHere;
        end
      end
    end

    assign rxValid[g] = validQ;
    assign rxByte[g]  = byteQ;
    assign rxChan[g]  = chanQ;

    assert_oe_after_req_R8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(oeQ) |-> $past(txReq[g]));

    assert_req_single_R8: assert property (@(posedge clk) disable iff (!rstN)
      txReq[g] |=> !txReq[g]);

    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
      validQ |=> !validQ);
  end
endmodule

// File: rtl/tdmStreamConverter.sv
module tdmStreamConverter
  import tdmPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic [1:0]        rxMode,
  input  logic              rxOddHalf,
  input  logic [1:0]        txMode,
  input  logic              txOddHalf,
  input  logic [LANES-1:0]  rxPin,
  output logic [LANES-1:0]  rxValid,
  output logic [CHAN_W-1:0] rxChan0,
  output logic [BYTE_W-1:0] rxByte0,
  output logic [CHAN_W-1:0] rxChan1,
  output logic [BYTE_W-1:0] rxByte1,
  output logic [LANES-1:0]  txReq,
  output logic [CHAN_W-1:0] txChan0,
  input  logic [BYTE_W-1:0] txData0,
  output logic [CHAN_W-1:0] txChan1,
  input  logic [BYTE_W-1:0] txData1,
  output logic [LANES-1:0]  txPin,
  output logic [LANES-1:0]  txOe
);
  rxStb_t            rxStb;
  txStb_t            txStb;
  logic [BYTE_W-1:0] txDataArr [LANES];
  logic [BYTE_W-1:0] rxByteArr [LANES];
  logic [CHAN_W-1:0] rxChanArr [LANES];

  assign txDataArr[0] = txData0;
  assign txDataArr[1] = txData1;
  assign rxByte0      = rxByteArr[0];
  assign rxByte1      = rxByteArr[1];
  assign rxChan0      = rxChanArr[0];
  assign rxChan1      = rxChanArr[1];
  assign txChan0      = txStb.chan0;
  assign txChan1      = txStb.chan1;

  tdmSlotCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync),
    .rxMode(rxMode), .rxOddHalf(rxOddHalf),
    .txMode(txMode), .txOddHalf(txOddHalf),
    .rxStb(rxStb), .txStb(txStb)
  );

  tdmLaneDatapath i_data (
    .clk(clk), .rstN(rstN), .rxStb(rxStb), .txStb(txStb),
    .rxPin(rxPin), .txData(txDataArr),
    .txReq(txReq), .txPin(txPin), .txOe(txOe),
    .rxValid(rxValid), .rxByte(rxByteArr), .rxChan(rxChanArr)
  );
endmodule

// File: tb/test_tdmStreamConverter.sv
`timescale 1ns/1ps
module test_tdmStreamConverter;
  logic       clk = 1'b0;
  logic       rstN, frameSync;
  logic [1:0] rxMode, txMode;
  logic       rxOddHalf, txOddHalf;
  logic [1:0] rxPin, rxValid, txReq, txPin, txOe;
  logic [5:0] rxChan0, rxChan1, txChan0, txChan1;
  logic [7:0] rxByte0, rxByte1, txData0, txData1;
  logic       manual;
  logic [1:0] manPin;
  logic       collect, expFF;
  int         total = 0, bad = 0;
  int         rxCount, byteBad, oe0, oe1;
  logic [63:0] seen;
  logic [5:0] ch;
  logic [7:0] by;

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input logic [5:0] c);
    return {c, 2'b10} ^ 8'h5A;
  endfunction

  function automatic int oeExp(input logic [1:0] m, input int lane);
    case (m)
      2'd0: return 1024;
      2'd1: return (lane == 0) ? 1024 : 0;
      2'd2: return (lane == 0) ? 512 : 0;
      default: return 0;
    endcase
  endfunction

  assign txData0 = pat(txChan0);
  assign txData1 = pat(txChan1);
  assign rxPin = manual ? manPin : {txOe[1] ? txPin[1] : 1'b1, txOe[0] ? txPin[0] : 1'b1};

  tdmStreamConverter i_tdmStreamConverter (
    .clk(clk), .rstN(rstN), .frameSync(frameSync),
    .rxMode(rxMode), .rxOddHalf(rxOddHalf), .txMode(txMode), .txOddHalf(txOddHalf),
    .rxPin(rxPin), .rxValid(rxValid), .rxChan0(rxChan0), .rxByte0(rxByte0),
    .rxChan1(rxChan1), .rxByte1(rxByte1), .txReq(txReq),
    .txChan0(txChan0), .txData0(txData0), .txChan1(txChan1), .txData1(txData1),
    .txPin(txPin), .txOe(txOe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // frame monitor for the vector walk
  always @(negedge clk) begin
    if (!collect) begin
      rxCount = 0; byteBad = 0; seen = '0; oe0 = 0; oe1 = 0;
    end else begin
      for (int l = 0; l < 2; l++) begin
        if (rxValid[l]) begin
          rxCount++;
          ch = (l == 1) ? rxChan1 : rxChan0;
          by = (l == 1) ? rxByte1 : rxByte0;
          if (by != (expFF ? 8'hFF : pat(ch))) byteBad++;
          if (rxMode == 2'd0 && ch[5] != l[0]) byteBad++;
          seen[ch] = 1'b1;
        end
      end
      if (txOe[0]) oe0++;
      if (txOe[1]) oe1++;
    end
  end

  // {rxMode, rxOdd, txMode, txOdd, expected count, expect all-ones}
  localparam logic [14:0] VECS [8] = '{
    {2'd0, 1'b0, 2'd0, 1'b0, 8'd64, 1'b0},  // R3 dual loopback
    {2'd1, 1'b0, 2'd1, 1'b0, 8'd64, 1'b0},  // R4 single loopback
    {2'd2, 1'b0, 2'd2, 1'b0, 8'd64, 1'b0},  // R5 half8 even
    {2'd2, 1'b1, 2'd2, 1'b1, 8'd64, 1'b0},  // R5 half8 odd
    {2'd3, 1'b0, 2'd3, 1'b0, 8'd0,  1'b0},  // R6 both off
    {2'd0, 1'b0, 2'd3, 1'b0, 8'd64, 1'b1},  // R10 rx dual, tx off
    {2'd2, 1'b1, 2'd2, 1'b0, 8'd64, 1'b1},  // R10 parity mismatch
    {2'd3, 1'b0, 2'd0, 1'b0, 8'd0,  1'b0}   // R10 rx off, tx dual
  };
  localparam logic [7:0] RXPAT = 8'h3C;

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int errs, m0, m1;
    rstN = 1'b0; frameSync = 1'b0; rxMode = 2'd0; txMode = 2'd0;
    rxOddHalf = 1'b0; txOddHalf = 1'b0; manual = 1'b0; manPin = 2'b00;
    collect = 1'b0; expFF = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(txOe == 0 && rxValid == 0, "R1", "outputs in reset", {txOe, rxValid}, 0);
    rstN = 1'b1;
    errs = 0;
    repeat (40) begin
      @(negedge clk);
      if (txOe != 0 || rxValid != 0 || txReq != 0) errs++;
    end
    check(errs == 0, "R1", "activity before first sync", errs, 0);

    // transmit timing and mapping, dual mode
    @(posedge clk); #1;
    rxMode = 2'd3; txMode = 2'd0; frameSync = 1'b1;
    @(negedge clk);
    check(txReq == 2'b11, "R8", "request in sync cycle", txReq, 3);
    check(txChan0 == 0 && txChan1 == 32, "R3", "requested channels", {txChan1, txChan0}, 32 << 6);
    @(posedge clk); #1;
    frameSync = 1'b0;
    m0 = 0; m1 = 0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (txPin[0] !== pat(6'd0)[7 - k/4] || !txOe[0]) m0++;
      if (txPin[1] !== pat(6'd32)[7 - k/4] || !txOe[1]) m1++;
    end
    check(m0 == 0, "R7", "lane0 MSB-first cells", m0, 0);
    check(m1 == 0, "R3", "lane1 slot0 carries ch32", m1, 0);
    repeat (992) @(negedge clk);
    check(txReq == 2'b11 && txChan0 == 0, "R2", "wrap without sync", {txReq, txChan0}, 3 << 6);

    // receive sampling point, single mode, manual pin
    @(posedge clk); #1;
    txMode = 2'd3; rxMode = 2'd1; manual = 1'b1; manPin = 2'b00; frameSync = 1'b1;
    @(posedge clk); #1;
    frameSync = 1'b0;
    for (int k = 0; k < 16; k++) begin
      manPin[0] = (k % 2 == 1) ? RXPAT[7 - k/2] : ~RXPAT[7 - k/2];
      manPin[1] = k[0];
      if (k == 15) check(rxValid == 2'b00, "R9", "no early valid", rxValid, 0);
      @(posedge clk); #1;
    end
    check(rxValid == 2'b01 && rxChan0 == 0, "R9", "valid after slot 0", {rxValid, rxChan0}, 1 << 6);
    check(rxByte0 == RXPAT, "R7", "last-cycle sampling", rxByte0, RXPAT);
    errs = 0;
    repeat (40) begin
      manPin[1] = ~manPin[1];
      @(posedge clk); #1;
      if (rxValid[1]) errs++;
    end
    check(errs == 0, "R4", "lane1 ignored in single", errs, 0);
    manual = 1'b0;

    // vector walk: one full loopback frame per entry
    for (int v = 0; v < 8; v++) begin
      @(posedge clk); #1;
      rxMode = VECS[v][14:13]; rxOddHalf = VECS[v][12];
      txMode = VECS[v][11:10]; txOddHalf = VECS[v][9];
      expFF = VECS[v][0]; frameSync = 1'b1;
      @(posedge clk); #1;
      frameSync = 1'b0;
      @(posedge clk); #1;
      collect = 1'b1;
      repeat (1024) @(posedge clk);
      #1;
      collect = 1'b0;
      check(rxCount == int'(VECS[v][8:1]) && (VECS[v][8:1] == 0 || seen == '1),
            "R10", $sformatf("vec%0d channel set (R3 R4 R5 R6)", v), rxCount, VECS[v][8:1]);
      check(byteBad == 0, "R10", $sformatf("vec%0d bytes", v), byteBad, 0);
      check(oe0 == oeExp(txMode, 0) && oe1 == oeExp(txMode, 1), "R5",
            $sformatf("vec%0d enable cycles (R6)", v), oe0 * 10000 + oe1,
            oeExp(txMode, 0) * 10000 + oeExp(txMode, 1));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule